// File: doc/BRIEF.md
# Two-Way Cache Miss Profiler

This block models only the tag side of a 64 KiB data cache. The cache has two ways, 512 sets and 64-byte lines. It watches a stream of memory references and counts first-level misses. Each reference carries a byte address and an access size. The block works out whether the bytes touched stay inside one line, run into the next line, or span more than that. It then looks up and updates the recency-ordered tags of every set the access touches.

A reference that misses in any set it touches produces one forward request toward the next cache level and adds one to a saturating miss counter. The request carries the reference's own address and size. References come in on a valid/ready handshake, and forward requests leave on another. A forward request that has not been accepted stalls the input. A synchronous clear zeroes the counter and leaves the tags alone.

Top module: `cache_miss_prof`

## Requirements
- R1: After reset every tag of every set and way is zero, so a first access with tag 0 hits in any set. After reset the counter reads 0, `ref_ready_o` is 1, and `fwd_valid_o` and `err_o` are 0.
- R2: The set index is address bits [14:6] and the tag is the address shifted right by 15. Lines are 64 bytes.
- R3: The set holding the last byte, at address + size − 1, decides where an access ends. A 64-byte access aligned to a line stays a single-line access.
- R4: A hit in way 0 leaves the set unchanged. A hit in way 1 swaps the two ways, so the hit tag becomes way 0.
- R5: On a miss the old way-0 tag moves to way 1, the old way-1 tag is dropped, and the new tag is written to way 0.
- R6: When the end set is the start set plus one, modulo 512 (this includes 511 to 0), the block probes and updates both sets with the start address's tag.
- R7: A reference with one or two missed halves raises the counter by exactly one. It also issues exactly one forward request carrying the original address and size.
- R8: An access whose end set is neither the start set nor the next set is illegal. `err_o` goes high for the one cycle after acceptance. Tags, counter and forward port are left unchanged.
- R9: A single-line access resolves in the cycle it is accepted. A straddling access takes one more cycle, during which `ref_ready_o` is 0.
- R10: While `fwd_valid_o` is high and not yet accepted, the forward address and size hold steady and `ref_ready_o` stays 0.
- R11: The miss counter saturates at all ones instead of wrapping. `clr_i` zeroes it on the next edge, takes priority over an increment, and leaves the tags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_valid_i | input | 1 | Reference present |
| ref_ready_o | output | 1 | Block can accept a reference |
| ref_addr_i | input | ADDR_W | Byte address of the reference |
| ref_size_i | input | SIZE_W | Access size in bytes (1 or more) |
| fwd_valid_o | output | 1 | Miss forward request pending |
| fwd_ready_i | input | 1 | Next level takes the forward request |
| fwd_addr_o | output | ADDR_W | Address of the missed reference |
| fwd_size_o | output | SIZE_W | Size of the missed reference |
| err_o | output | 1 | One-cycle pulse for an illegal span |
| clr_i | input | 1 | Synchronous counter clear |
| miss_cnt_o | output | CNT_W | Saturating first-level miss count |

## Verification
A fixed vector walk sets up tag collisions in set 0 that separate a way-0 hit, a way-1 hit with swap, and an eviction. It also covers a line-aligned 64-byte access, which catches an end address computed without the minus one, and straddles that miss in one half or in both halves. A wrap from set 511 to set 0 and an over-long illegal span complete the walk. After that, a random stream draws from a few tags and is biased toward sets 511, 0 and 1 and toward line-crossing sizes. A reference model in the bench decides hit or miss and the expected latency for each reference. Forward acceptance is delayed by varying amounts to exercise the stall. A second instance with a 3-bit counter shows saturation, and a clear in the middle of the run shows that the tags survive.

// File: rtl/cache_prof_pkg.sv
package cache_prof_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SECOND,
    ST_FWD
  } prof_state_e;

  typedef enum logic [1:0] {
    SPAN_ONE,
    SPAN_TWO,
    SPAN_BAD
  } span_e;
endpackage

// File: rtl/prof_addr_split.sv
module prof_addr_split
  import cache_prof_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SIZE_W    = 8,
  parameter int LINE_BITS = 6,
  parameter int SET_BITS  = 9,
  localparam int TAG_W    = ADDR_W - LINE_BITS - SET_BITS
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [SIZE_W-1:0]   size_i,
  output logic [SET_BITS-1:0] set_start_o,
  output logic [SET_BITS-1:0] set_end_o,
  output logic [TAG_W-1:0]    tag_o,
  output span_e               span_o
);
  logic [ADDR_W-1:0]   end_addr;
  logic [SET_BITS-1:0] set_next;

  // last byte touched, not one past it
  assign end_addr    = addr_i + ADDR_W'(size_i) - ADDR_W'(1);
  assign set_start_o = addr_i[LINE_BITS +: SET_BITS];
  assign set_end_o   = end_addr[LINE_BITS +: SET_BITS];
  assign tag_o       = addr_i[ADDR_W-1 -: TAG_W];
  assign set_next    = set_start_o + SET_BITS'(1);

  always_comb begin
    if (set_end_o == set_start_o)   span_o = SPAN_ONE;
    else if (set_end_o == set_next) span_o = SPAN_TWO;
    else                            span_o = SPAN_BAD;
  end
endmodule

// File: rtl/prof_tag_store.sv
module prof_tag_store #(
  parameter int SET_BITS = 9,
  parameter int TAG_W    = 17,
  localparam int NSETS   = 1 << SET_BITS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SET_BITS-1:0] lk_set_i,
  input  logic [TAG_W-1:0]    lk_tag_i,
  input  logic                upd_en_i,
  output logic                hit_o
);
  logic [TAG_W-1:0] mru_q [NSETS];
  logic [TAG_W-1:0] lru_q [NSETS];
  logic hit_mru, hit_lru;

  assign hit_mru = (mru_q[lk_set_i] == lk_tag_i);
  assign hit_lru = (lru_q[lk_set_i] == lk_tag_i);
  assign hit_o   = hit_mru | hit_lru;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NSETS; s++) begin
        mru_q[s] <= '0;
        lru_q[s] <= '0;
      end
    end else if (upd_en_i && !hit_mru) begin
      // way-1 hit and miss both push the old MRU down
      lru_q[lk_set_i] <= mru_q[lk_set_i];
      mru_q[lk_set_i] <= lk_tag_i;
    end
  end

  AST_MRU_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en_i |=> mru_q[$past(lk_set_i)] == $past(lk_tag_i)); // R5

  AST_MRU_HIT_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && hit_mru) |=> lru_q[$past(lk_set_i)] == $past(lru_q[lk_set_i])); // R4
endmodule

// File: rtl/prof_miss_counter.sv
module prof_miss_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (inc_i && !(&cnt_q)) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;

  AST_CNT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0); // R11
  AST_CNT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && (&cnt_q)) |=> (&cnt_q)); // R11
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1))); // R7
endmodule

// File: rtl/cache_miss_prof.sv
module cache_miss_prof
  import cache_prof_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SIZE_W    = 8,
  parameter int LINE_BITS = 6,
  parameter int SET_BITS  = 9,
  parameter int CNT_W     = 64,
  localparam int TAG_W    = ADDR_W - LINE_BITS - SET_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_valid_i,
  output logic              ref_ready_o,
  input  logic [ADDR_W-1:0] ref_addr_i,
  input  logic [SIZE_W-1:0] ref_size_i,
  output logic              fwd_valid_o,
  input  logic              fwd_ready_i,
  output logic [ADDR_W-1:0] fwd_addr_o,
  output logic [SIZE_W-1:0] fwd_size_o,
  output logic              err_o,
  input  logic              clr_i,
  output logic [CNT_W-1:0]  miss_cnt_o
);
  prof_state_e         state_q, state_d;
  logic [SET_BITS-1:0] set_start, set_end, set2_q;
  logic [TAG_W-1:0]    tag, tag_q;
  span_e               span;
  logic [ADDR_W-1:0]   addr_q;
  logic [SIZE_W-1:0]   size_q;
  logic                miss1_q, err_q;
  logic [SET_BITS-1:0] lk_set;
  logic [TAG_W-1:0]    lk_tag;
  logic                upd_en, hit, accept, launch;

  prof_addr_split #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .LINE_BITS(LINE_BITS), .SET_BITS(SET_BITS)
  ) u_split (
    .addr_i(ref_addr_i), .size_i(ref_size_i),
    .set_start_o(set_start), .set_end_o(set_end), .tag_o(tag), .span_o(span)
  );

  assign ref_ready_o = (state_q == ST_IDLE);
  assign accept      = ref_valid_i && ref_ready_o;
  assign lk_set      = (state_q == ST_SECOND) ? set2_q : set_start;
  assign lk_tag      = (state_q == ST_SECOND) ? tag_q  : tag;
  assign upd_en      = (accept && span != SPAN_BAD) || (state_q == ST_SECOND);

  prof_tag_store #(.SET_BITS(SET_BITS), .TAG_W(TAG_W)) u_tags (
    .clk_i(clk_i), .rst_ni(rst_ni), .lk_set_i(lk_set), .lk_tag_i(lk_tag),
    .upd_en_i(upd_en), .hit_o(hit)
  );

  always_comb begin
    state_d = state_q;
    launch  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        if (span == SPAN_ONE && !hit) begin
          launch  = 1'b1;
          state_d = ST_FWD;
        end else if (span == SPAN_TWO) begin
          state_d = ST_SECOND;
        end
      end
      ST_SECOND: begin
        if (!hit || miss1_q) begin
          launch  = 1'b1;
          state_d = ST_FWD;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_FWD: if (fwd_ready_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      set2_q  <= '0;
      tag_q   <= '0;
      addr_q  <= '0;
      size_q  <= '0;
      miss1_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= accept && (span == SPAN_BAD);
      if (accept && span != SPAN_BAD) begin
        set2_q  <= set_end;
        tag_q   <= tag;
        addr_q  <= ref_addr_i;
        size_q  <= ref_size_i;
        miss1_q <= !hit;
      end
    end
  end

  prof_miss_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .inc_i(launch), .cnt_o(miss_cnt_o)
  );

  assign fwd_valid_o = (state_q == ST_FWD);
  assign fwd_addr_o  = addr_q;
  assign fwd_size_o  = size_q;
  assign err_o       = err_q;

  AST_FWD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_valid_o && !fwd_ready_i) |=> fwd_valid_o && $stable(fwd_addr_o) && $stable(fwd_size_o)); // R10
  AST_FWD_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |-> !ref_ready_o); // R10
  AST_ERR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !fwd_valid_o && $stable(miss_cnt_o)); // R8
  AST_FWD_COUNTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(fwd_valid_o) && !$past(clr_i)) |->
      (miss_cnt_o == $past(miss_cnt_o) + CNT_W'(1)) || (&$past(miss_cnt_o))); // R7
endmodule

// File: tb/cache_miss_prof_tb_top.sv
module cache_miss_prof_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ref_valid = 1'b0, fwd_ready = 1'b0, clr = 1'b0;
  logic [31:0] ref_addr = '0;
  logic [7:0]  ref_size = 8'd1;
  logic        ref_ready, fwd_valid, err;
  logic [31:0] fwd_addr;
  logic [7:0]  fwd_size;
  logic [63:0] cnt;
  logic        s_ready, s_fv, s_err;
  logic [31:0] s_fa;
  logic [7:0]  s_fs;
  logic [2:0]  s_cnt;

  int checks = 0, failures = 0, exp_cnt = 0;
  logic [16:0] m_w0 [512];
  logic [16:0] m_w1 [512];

  always #5 clk = ~clk;

  cache_miss_prof dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .ref_valid_i(ref_valid), .ref_ready_o(ref_ready),
    .ref_addr_i(ref_addr), .ref_size_i(ref_size), .fwd_valid_o(fwd_valid),
    .fwd_ready_i(fwd_ready), .fwd_addr_o(fwd_addr), .fwd_size_o(fwd_size),
    .err_o(err), .clr_i(clr), .miss_cnt_o(cnt)
  );

  cache_miss_prof #(.CNT_W(3)) dut_sat_i (
    .clk_i(clk), .rst_ni(rst_ni), .ref_valid_i(ref_valid), .ref_ready_o(s_ready),
    .ref_addr_i(ref_addr), .ref_size_i(ref_size), .fwd_valid_o(s_fv),
    .fwd_ready_i(fwd_ready), .fwd_addr_o(s_fa), .fwd_size_o(s_fs),
    .err_o(s_err), .clr_i(clr), .miss_cnt_o(s_cnt)
  );

  // {addr, size, expect_miss, expect_err}
  localparam logic [41:0] VEC [12] = '{
    {32'h0000_0000, 8'd4,   1'b0, 1'b0},  // R1 zero tag hits
    {32'h0000_8000, 8'd4,   1'b1, 1'b0},  // R2/R5 tag 1 miss
    {32'h0000_0010, 8'd8,   1'b0, 1'b0},  // R4 way-1 hit swap
    {32'h0001_0000, 8'd4,   1'b1, 1'b0},  // R5 evicts tag 1
    {32'h0000_8004, 8'd4,   1'b1, 1'b0},  // R5 tag 1 gone
    {32'h0000_803E, 8'd4,   1'b1, 1'b0},  // R6/R7 second half misses
    {32'h0000_807C, 8'd4,   1'b0, 1'b0},  // R6 set 1 was filled
    {32'h0000_7FFE, 8'd4,   1'b1, 1'b0},  // R6 wrap 511->0
    {32'h0000_0040, 8'd64,  1'b0, 1'b0},  // R3 exact line, single
    {32'h0000_0100, 8'd200, 1'b0, 1'b1},  // R8 illegal span
    {32'h0000_8010, 8'd1,   1'b0, 1'b0},  // R8 set 0 untouched
    {32'h0002_00BF, 8'd2,   1'b1, 1'b0}   // R7 both halves miss, one count
  };

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic probe(input logic [8:0] s, input logic [16:0] t, output bit h);
    if (m_w0[s] == t) h = 1'b1;
    else if (m_w1[s] == t) begin
      h = 1'b1; m_w1[s] = m_w0[s]; m_w0[s] = t;
    end else begin
      h = 1'b0; m_w1[s] = m_w0[s]; m_w0[s] = t;
    end
  endtask

  task automatic model(input logic [31:0] a, input logic [7:0] sz,
                       output bit miss, output bit ill, output bit two);
    logic [31:0] e;
    logic [8:0]  s1, s2;
    bit h1, h2;
    e = a + 32'(sz) - 32'd1;
    s1 = a[14:6]; s2 = e[14:6];
    miss = 0; ill = 0; two = 0;
    if (s1 == s2) begin
      probe(s1, a[31:15], h1); miss = !h1;
    end else if (s2 == s1 + 9'd1) begin
      two = 1;
      probe(s1, a[31:15], h1);
      probe(s2, a[31:15], h2);
      miss = !h1 || !h2;
    end else ill = 1;
  endtask

  task automatic do_ref(input logic [31:0] a, input logic [7:0] sz, input bit use_exp,
                        input bit e_miss, input bit e_err, input int wait_cyc);
    bit m_miss, m_ill, m_two, x_miss, x_err;
    int pre;
    model(a, sz, m_miss, m_ill, m_two);
    x_miss = use_exp ? e_miss : m_miss;
    x_err  = use_exp ? e_err  : m_ill;
    pre = exp_cnt;
    @(negedge clk);
    while (!ref_ready) @(negedge clk);
    ref_valid = 1'b1; ref_addr = a; ref_size = sz;
    @(negedge clk);
    ref_valid = 1'b0;
    if (m_two) begin
      check(!ref_ready && !fwd_valid && !err, "R9", "straddle second cycle busy",
            {ref_ready, fwd_valid, err}, 0);
      @(negedge clk);
    end
    check(err == x_err, "R8", "error flag", err, x_err);
    check(fwd_valid == x_miss, x_err ? "R8" : (m_two ? "R7" : "R5"), "miss decision",
          fwd_valid, x_miss);
    if (fwd_valid) begin
      exp_cnt++;
      check(fwd_addr == a && fwd_size == sz, "R7", "forward addr/size",
            {fwd_addr, fwd_size}, {a, sz});
      check(cnt == 64'(exp_cnt), "R7", "count after miss", cnt, exp_cnt);
      check(s_cnt == 3'((exp_cnt > 7) ? 7 : exp_cnt), "R11", "saturating count",
            s_cnt, (exp_cnt > 7) ? 7 : exp_cnt);
      for (int i = 0; i < wait_cyc; i++) begin
        @(negedge clk);
        check(fwd_valid && !ref_ready && fwd_addr == a, "R10", "hold while stalled",
              {fwd_valid, ref_ready}, 2'b10);
      end
      fwd_ready = 1'b1;
      @(negedge clk);
      fwd_ready = 1'b0;
      check(!fwd_valid && ref_ready, "R10", "forward taken once", fwd_valid, 0);
    end else begin
      check(ref_ready == 1'b1, "R9", "done in expected cycle", ref_ready, 1);
      check(cnt == 64'(pre), "R8", "count unchanged", cnt, pre);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int s = 0; s < 512; s++) begin m_w0[s] = '0; m_w1[s] = '0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(ref_ready && !fwd_valid && !err && cnt == 0, "R1", "reset state",
          {ref_ready, fwd_valid, err}, 3'b100);

    for (int v = 0; v < 12; v++)
      do_ref(VEC[v][41:10], VEC[v][9:2], 1'b1, VEC[v][1], VEC[v][0], v % 3);

    // R11 clear keeps tags: set 0 way 0 holds tag 1 from vector 10
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    check(cnt == 0 && s_cnt == 0, "R11", "clear zeroes count", cnt, 0);
    exp_cnt = 0;
    do_ref(32'h0000_8020, 8'd4, 1'b1, 1'b0, 1'b0, 0);  // R11 still hits after clear

    for (int n = 0; n < 400; n++) begin
      int r;
      logic [8:0]  st;
      logic [31:0] a;
      logic [7:0]  sz;
      r = $urandom_range(0, 5);
      st = (r == 0) ? 9'd511 : (r == 1) ? 9'd0 : (r == 2) ? 9'd1 : 9'($urandom_range(0, 511));
      a = {15'($urandom_range(0, 3)), 2'b00, st, 6'($urandom_range(0, 63))};
      sz = ($urandom_range(0, 9) == 0) ? 8'(65 + $urandom_range(0, 100))
                                       : 8'(1 + $urandom_range(0, 63));
      do_ref(a, sz, 1'b0, 1'b0, 1'b0, $urandom_range(0, 2));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule